// File: doc/BRIEF.md
# Memory-Mapped Software Reset Trigger

This block is a register-bus slave that owns one 8-byte control word. Software starts a chip-level reset action by writing a command bit into that word. The block decodes the write and raises a level request toward the reset controller. It keeps that request high until the controller reports completion with a one-cycle acknowledge.

Three reset kinds exist: a chip-wide warm reset, a chip-wide debug reset, and an external-interrupt reset. The external-interrupt reset is aimed only at the cores selected by a steering mask input. That mask is sampled at the moment of the write and carried with the request. Only one request can be in flight at a time. Writes that arrive while a request is pending are acknowledged on the bus and then dropped. Reads of the word always return zero, because each command clears itself once its reset action has finished.

Top module: `sw_rst_trigger`

## Requirements
- R1: A bus transfer is claimed only when its address lies in 0x89_0000_0808 to 0x89_0000_080F (address bits 39:3 match; bits 2:0 are ignored). A claimed transfer gets `bus_ack` high for exactly one cycle, on the clock after the transfer is sampled. An unclaimed transfer gets no ack and has no effect on any request.
- R2: A claimed read returns `bus_rdata` equal to zero, with the same one-cycle ack.
- R3: A claimed write, with data bit 0 set and no request pending, raises `warm_req` from the next clock.
- R4: A claimed write, with data bit 1 set, bit 0 clear and no request pending, raises `xtrn_req` from the next clock. In that case `xtrn_targets` equals the value of `steer_mask` at the write.
- R5: A claimed write, with data bit 3 set, bits 0 and 1 clear and no request pending, raises `dbg_req` from the next clock.
- R6: When several of bits 0, 1 and 3 are set, only one request is raised. Bit 0 wins over bit 1, and bit 1 wins over bit 3. At most one of the three requests is ever high.
- R7: Data bits 2 and 4 to 63 are ignored. A claimed write with none of bits 0, 1 or 3 set is acknowledged and raises no request.
- R8: A raised request stays high until `rc_done` is sampled high. It is low from the clock that samples `rc_done`. `busy` is high exactly while a request is high. `rc_done` while idle has no effect.
- R9: While `busy` is high, a claimed write is acknowledged and discarded: the pending request and its targets do not change, and no other request appears after completion.
- R10: `xtrn_targets` holds the captured mask while `xtrn_req` is high, and is zero otherwise. Changes of `steer_mask` after the write do not alter it.
- R11: With `rst_n` low at a clock edge, all requests, `busy`, `bus_ack` and `xtrn_targets` are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Transfer present this cycle (one cycle per transfer) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 40 | Byte address |
| bus_wdata | input | 64 | Write data (command word) |
| bus_ack | output | 1 | One-cycle completion response for a claimed transfer |
| bus_rdata | output | 64 | Read data, always zero |
| steer_mask | input | 8 | Per-core selection for the external-interrupt reset |
| rc_done | input | 1 | Completion pulse from the reset controller |
| warm_req | output | 1 | Chip-wide warm reset request (level) |
| xtrn_req | output | 1 | External-interrupt reset request (level) |
| dbg_req | output | 1 | Chip-wide debug reset request (level) |
| xtrn_targets | output | 8 | Cores addressed by the external-interrupt request |
| busy | output | 1 | A request is pending |

## Verification
The checker watches several properties on every cycle. It checks that the ack follows exactly the claimed transfers, that at most one request is high, and that each rising request traces back to a claimed write carrying the bit that wins priority. It also checks that pending requests and captured targets stay put until completion and that completion clears them the next cycle. The directed scenarios cover the behaviours a cycle-local property cannot pin down. These are the exact decode boundaries and the read-data value. They also include the ignored bits and an all-ignored command word, the discard of a write made while busy (seen again after completion), mask changes during a request, and reset in mid-request.

// File: rtl/swrst_pkg.sv
// Package: shared constants and command selection for the software reset trigger.
// Assumes a 64-bit command word with the reset-kind bits at fixed positions.
package swrst_pkg;

    // Command bit positions inside the written word (decoded by software contract)
    localparam int WARM_BIT = 0;
    localparam int XTRN_BIT = 1;
    localparam int DBG_BIT  = 3;

    // Number of reset kinds and their index in the request vector
    localparam int NKIND    = 3;
    localparam int K_WARM   = 0;
    localparam int K_XTRN   = 1;
    localparam int K_DBG    = 2;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_WARM = 2'd1,
        CMD_XTRN = 2'd2,
        CMD_DBG  = 2'd3
    } swrst_cmd_e;

    // Fixed-priority choice: warm over external-interrupt over debug
    function automatic swrst_cmd_e pick_cmd(input logic w, input logic x, input logic d);
        if (w)      return CMD_WARM;
        else if (x) return CMD_XTRN;
        else if (d) return CMD_DBG;
        else        return CMD_NONE;
    endfunction

    // One-hot request vector for a selected command
    function automatic logic [NKIND-1:0] cmd_onehot(input swrst_cmd_e c);
        logic [NKIND-1:0] v;
        v = '0;
        case (c)
            CMD_WARM: v[K_WARM] = 1'b1;
            CMD_XTRN: v[K_XTRN] = 1'b1;
            CMD_DBG:  v[K_DBG]  = 1'b1;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/swrst_addr_match.sv
// Module: swrst_addr_match
// Compares a byte address against one 8-byte aligned location.
// Assumes BASE_ADDR is 8-byte aligned; byte-offset bits are not compared.
module swrst_addr_match #(
    parameter int              ADDR_W    = 40,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 40'h89_0000_0808
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int OFS_W = 3;

    logic unused_ofs;

    // Upper-bit equality decides the claim
    always_comb begin
        hit = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
    end

    assign unused_ofs = ^addr[OFS_W-1:0];
endmodule

// File: rtl/swrst_cmd_decode.sv
// Module: swrst_cmd_decode
// Reduces the three command bits of a written word to at most one request.
// Assumes the caller passes only the command bits; all other bits are dropped upstream.
module swrst_cmd_decode
    import swrst_pkg::*;
(
    input  logic             bit_warm,
    input  logic             bit_xtrn,
    input  logic             bit_dbg,
    output logic [NKIND-1:0] set_oh,
    output logic             any_cmd
);
    swrst_cmd_e sel;

    // Priority selection and one-hot expansion
    always_comb begin
        sel     = pick_cmd(bit_warm, bit_xtrn, bit_dbg);
        set_oh  = cmd_onehot(sel);
        any_cmd = (sel != CMD_NONE);
    end
endmodule

// File: rtl/swrst_req_hold.sv
// Module: swrst_req_hold
// Holds one pending reset request per kind and the captured steering mask.
// Assumes set_oh is one-hot or zero and is only presented when accept is high.
module swrst_req_hold
    import swrst_pkg::*;
#(
    parameter int NCORE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [NKIND-1:0] set_oh,
    input  logic             done,
    input  logic [NCORE-1:0] mask_in,
    output logic [NKIND-1:0] req,
    output logic [NCORE-1:0] targets,
    output logic             busy
);
    logic [NKIND-1:0] req_q;
    logic [NCORE-1:0] tgt_q;

    // One request flop per reset kind: set on accept, cleared on completion
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        always_ff @(posedge clk) begin
            if (!rst_n)                 req_q[k] <= 1'b0;
            else if (done && busy)      req_q[k] <= 1'b0;
            else if (accept && set_oh[k]) req_q[k] <= 1'b1;
        end
    end

    // Steering mask captured with an external-interrupt request, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                        tgt_q <= '0;
        else if (done && busy)             tgt_q <= '0;
        else if (accept && set_oh[K_XTRN]) tgt_q <= mask_in;
    end

    // Pending indication
    always_comb begin
        busy = |req_q;
    end

    assign req     = req_q;
    assign targets = tgt_q;
endmodule

// File: rtl/swrst_bus_rsp.sv
// Module: swrst_bus_rsp
// Produces the one-cycle bus response for claimed transfers.
// Assumes the master presents each transfer for a single cycle.
module swrst_bus_rsp #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    logic ack_q;

    // Registered acknowledge, one clock after the claimed transfer
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= claim;
    end

    assign ack   = ack_q;
    assign rdata = '0;
endmodule

// File: rtl/sw_rst_trigger.sv
// Module: sw_rst_trigger
// Software reset trigger: decodes one command word and raises a held reset
// request toward the reset controller until it acknowledges completion.
// Assumes single-cycle bus transfers and a one-cycle rc_done pulse.
module sw_rst_trigger
    import swrst_pkg::*;
#(
    parameter int                ADDR_W    = 40,
    parameter int                DATA_W    = 64,
    parameter int                NCORE     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 40'h89_0000_0808
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCORE-1:0]  steer_mask,
    input  logic              rc_done,
    output logic              warm_req,
    output logic              xtrn_req,
    output logic              dbg_req,
    output logic [NCORE-1:0]  xtrn_targets,
    output logic              busy
);
    logic             hit;
    logic             claim;
    logic             wr_fire;
    logic             accept;
    logic             any_cmd;
    logic [NKIND-1:0] set_oh;
    logic [NKIND-1:0] req_vec;
    logic             unused_wdata;

    swrst_addr_match #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_match (
        .addr (bus_addr),
        .hit  (hit)
    );

    swrst_cmd_decode u_dec (
        .bit_warm (bus_wdata[WARM_BIT]),
        .bit_xtrn (bus_wdata[XTRN_BIT]),
        .bit_dbg  (bus_wdata[DBG_BIT]),
        .set_oh   (set_oh),
        .any_cmd  (any_cmd)
    );

    // Transfer qualification: claim, write with a command, idle
    always_comb begin
        claim   = bus_valid && hit;
        wr_fire = claim && bus_write;
        accept  = wr_fire && any_cmd && !busy;
    end

    swrst_req_hold #(.NCORE(NCORE)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .set_oh  (set_oh),
        .done    (rc_done),
        .mask_in (steer_mask),
        .req     (req_vec),
        .targets (xtrn_targets),
        .busy    (busy)
    );

    swrst_bus_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk   (clk),
        .rst_n (rst_n),
        .claim (claim),
        .ack   (bus_ack),
        .rdata (bus_rdata)
    );

    assign warm_req = req_vec[K_WARM];
    assign xtrn_req = req_vec[K_XTRN];
    assign dbg_req  = req_vec[K_DBG];

    assign unused_wdata = ^{bus_wdata[DATA_W-1:DBG_BIT+1], bus_wdata[2]};
endmodule

// File: rtl/swrst_checker.sv
// Module: swrst_checker
// Cycle-level properties of the software reset trigger, bound to its top.
// Assumes the same parameters as the bound instance.
module swrst_checker #(
    parameter int                ADDR_W    = 40,
    parameter int                DATA_W    = 64,
    parameter int                NCORE     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 40'h89_0000_0808
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              rc_done,
    input logic              warm_req,
    input logic              xtrn_req,
    input logic              dbg_req,
    input logic [NCORE-1:0]  xtrn_targets,
    input logic              busy
);
    logic in_win;
    assign in_win = bus_valid && (bus_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);

    assert_ack_on_claim_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |=> bus_ack);
    assert_no_ack_unclaimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |=> !bus_ack);
    assert_warm_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_req) |-> $past(in_win && bus_write && bus_wdata[0]));
    assert_xtrn_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xtrn_req) |-> $past(in_win && bus_write && bus_wdata[1] && !bus_wdata[0]));
    assert_dbg_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_req) |-> $past(in_win && bus_write && bus_wdata[3] && !bus_wdata[1] && !bus_wdata[0]));
    assert_single_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({warm_req, xtrn_req, dbg_req}));
    assert_hold_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rc_done |=> $stable({warm_req, xtrn_req, dbg_req}));
    assert_release_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rc_done |=> !busy);
    assert_busy_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (warm_req || xtrn_req || dbg_req));
    assert_targets_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xtrn_req && !rc_done |=> $stable(xtrn_targets));
    assert_targets_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !xtrn_req |-> (xtrn_targets == '0));
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (!busy && !bus_ack && xtrn_targets == '0));
endmodule

bind sw_rst_trigger swrst_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCORE(NCORE), .BASE_ADDR(BASE_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .rc_done(rc_done), .warm_req(warm_req), .xtrn_req(xtrn_req),
    .dbg_req(dbg_req), .xtrn_targets(xtrn_targets), .busy(busy)
);

// File: tb/sw_rst_trigger_tb_top.sv
// Directed bench for the software reset trigger.
module sw_rst_trigger_tb_top;
    localparam int ADDR_W = 40;
    localparam int DATA_W = 64;
    localparam int NCORE  = 8;
    localparam logic [ADDR_W-1:0] BASE = 40'h89_0000_0808;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_ack;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCORE-1:0]  steer_mask = '0;
    logic              rc_done = 1'b0;
    logic              warm_req, xtrn_req, dbg_req, busy;
    logic [NCORE-1:0]  xtrn_targets;

    int n_chk = 0;
    int n_bad = 0;
    logic              got_ack;
    logic [DATA_W-1:0] got_rdata;

    always #10 clk = ~clk;

    sw_rst_trigger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCORE(NCORE), .BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .steer_mask(steer_mask), .rc_done(rc_done),
        .warm_req(warm_req), .xtrn_req(xtrn_req), .dbg_req(dbg_req),
        .xtrn_targets(xtrn_targets), .busy(busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Request outputs packed as {dbg, xtrn, warm}
    function automatic logic [2:0] reqs();
        return {dbg_req, xtrn_req, warm_req};
    endfunction

    // One bus transfer; ack and rdata sampled after the responding edge
    task automatic bus_op(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        got_ack = bus_ack; got_rdata = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk); rc_done = 1'b1;
        @(posedge clk); #2;
        @(negedge clk); rc_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        @(posedge clk); #2;
        chk("R11 reset reqs", {61'd0, reqs()}, 64'd0);
        chk("R11 reset busy/ack", {62'd0, busy, bus_ack}, 64'd0);
        chk("R11 reset targets", {56'd0, xtrn_targets}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_read();
        bus_op(1'b0, BASE, '0);
        chk("R2 read ack", {63'd0, got_ack}, 64'd1);
        chk("R2 read data", got_rdata, 64'd0);
        bus_op(1'b0, BASE + 40'd7, '0);
        chk("R1 read top byte ack", {63'd0, got_ack}, 64'd1);
        chk("R2 read top byte data", got_rdata, 64'd0);
    endtask

    task automatic t_miss();
        bus_op(1'b1, BASE + 40'd8, 64'h1);
        chk("R1 miss above ack", {63'd0, got_ack}, 64'd0);
        bus_op(1'b1, BASE - 40'd1, 64'h1);
        chk("R1 miss below ack", {63'd0, got_ack}, 64'd0);
        bus_op(1'b1, 40'h88_0000_0808, 64'h1);
        chk("R1 miss high bits ack", {63'd0, got_ack}, 64'd0);
        idle(2);
        chk("R1 miss no request", {62'd0, busy, |reqs()}, 64'd0);
    endtask

    task automatic t_warm();
        bus_op(1'b1, BASE + 40'd4, 64'h1);
        chk("R1 write ack", {63'd0, got_ack}, 64'd1);
        chk("R3 warm raised", {61'd0, reqs()}, 64'd1);
        chk("R8 busy raised", {63'd0, busy}, 64'd1);
        idle(3);
        chk("R8 warm held", {61'd0, reqs()}, 64'd1);
        pulse_done();
        chk("R8 warm released", {62'd0, busy, warm_req}, 64'd0);
        pulse_done();
        chk("R8 idle done no effect", {62'd0, busy, |reqs()}, 64'd0);
    endtask

    task automatic t_xtrn();
        steer_mask = 8'h05;
        bus_op(1'b1, BASE, 64'h2);
        chk("R4 xtrn raised", {61'd0, reqs()}, 64'd2);
        chk("R4 targets captured", {56'd0, xtrn_targets}, 64'h05);
        steer_mask = 8'hA0;
        idle(2);
        chk("R10 targets after mask change", {56'd0, xtrn_targets}, 64'h05);
        pulse_done();
        chk("R10 targets cleared", {56'd0, xtrn_targets}, 64'h00);
        chk("R8 xtrn released", {61'd0, reqs()}, 64'd0);
    endtask

    task automatic t_dbg();
        bus_op(1'b1, BASE, 64'h8);
        chk("R5 dbg raised", {61'd0, reqs()}, 64'd4);
        chk("R10 targets zero for dbg", {56'd0, xtrn_targets}, 64'h00);
        pulse_done();
        chk("R8 dbg released", {61'd0, reqs()}, 64'd0);
    endtask

    task automatic t_prio();
        steer_mask = 8'hFF;
        bus_op(1'b1, BASE, 64'hB);
        chk("R6 bits 0,1,3 -> warm", {61'd0, reqs()}, 64'd1);
        pulse_done();
        bus_op(1'b1, BASE, 64'hA);
        chk("R6 bits 1,3 -> xtrn", {61'd0, reqs()}, 64'd2);
        chk("R6 targets", {56'd0, xtrn_targets}, 64'hFF);
        pulse_done();
        bus_op(1'b1, BASE, 64'h9);
        chk("R6 bits 0,3 -> warm", {61'd0, reqs()}, 64'd1);
        pulse_done();
    endtask

    task automatic t_ignored();
        bus_op(1'b1, BASE, 64'hFFFF_FFFF_FFFF_FFF4);
        chk("R7 ignored bits ack", {63'd0, got_ack}, 64'd1);
        idle(2);
        chk("R7 ignored bits no request", {62'd0, busy, |reqs()}, 64'd0);
        bus_op(1'b1, BASE, 64'h0);
        chk("R7 zero word no request", {62'd0, busy, |reqs()}, 64'd0);
        bus_op(1'b1, BASE, 64'h10);
        chk("R7 bit 4 alone no request", {62'd0, busy, |reqs()}, 64'd0);
    endtask

    task automatic t_busy();
        steer_mask = 8'h03;
        bus_op(1'b1, BASE, 64'h2);
        chk("R4 xtrn before busy test", {61'd0, reqs()}, 64'd2);
        steer_mask = 8'hC0;
        bus_op(1'b1, BASE, 64'h8);
        chk("R9 write while busy acked", {63'd0, got_ack}, 64'd1);
        chk("R9 request unchanged", {61'd0, reqs()}, 64'd2);
        bus_op(1'b1, BASE, 64'h2);
        chk("R9 targets unchanged", {56'd0, xtrn_targets}, 64'h03);
        pulse_done();
        idle(2);
        chk("R9 nothing queued", {62'd0, busy, |reqs()}, 64'd0);
    endtask

    task automatic t_reset_mid();
        steer_mask = 8'h11;
        bus_op(1'b1, BASE, 64'h2);
        chk("R4 xtrn before reset", {61'd0, reqs()}, 64'd2);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        chk("R11 mid reset reqs", {62'd0, busy, |reqs()}, 64'd0);
        chk("R11 mid reset targets", {56'd0, xtrn_targets}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_read();
        t_miss();
        t_warm();
        t_xtrn();
        t_dbg();
        t_prio();
        t_ignored();
        t_busy();
        t_reset_mid();
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule